// File: doc/BRIEF.md
# Ping-Pong Segment Writer

This block keeps a stream of converter results flowing into one linear buffer without a gap at segment boundaries. Two transfer channels take turns. Each channel owns one segment of the buffer and a beat count. While one channel runs, the other already holds its start address and a full count. On every sample-ready strobe the running channel stores one beat of results and advances its address. When its count runs out, it clears its own enable bit and sets its partner's enable bit on the same clock edge. The next strobe is therefore served by the partner, even when it arrives on the very next cycle.

The channel that has just finished is reloaded at once, while its partner runs. It gets the segment that follows the partner's segment, taken modulo the buffer size. In this way the write address climbs through the whole buffer and wraps back to zero. Each trigger carries `LANES` results packed side by side. The address counts single results, so it steps by `LANES` per beat. A `start` pulse arms both channels and begins at address zero. A strobe that arrives while no channel is enabled raises a sticky overrun flag.

The defaults are four results per trigger, 2500 beats per segment (10000 results) and ten segments (100000 results). A segment may not exceed 65536 beats.

Top module: `pp_xfer_pingpong`

## Requirements
- R1: After reset, `wr_en` and `overrun` are 0, `active_ch` is 0, and no channel is enabled.
- R2: A `start` pulse enables channel 0 with destination 0 and arms channel 1, still disabled, with destination `SEG_BEATS*LANES`. Both channels receive a count of `SEG_BEATS`.
- R3: Each strobe accepted by an enabled channel raises `wr_en` for exactly the one following cycle. That write carries `wr_data` equal to the sampled `sample_data` and `wr_addr` equal to the channel's current destination. The destination then advances by `LANES`. A cycle with no strobe produces no write.
- R4: From `start` on, exactly one channel is enabled at any time. `active_ch` reports which one (0 or 1).
- R5: The edge that accepts a channel's `SEG_BEATS`-th strobe also disables that channel and enables its partner. A strobe on the next cycle is written by the partner, and `active_ch` toggles.
- R6: The finished channel is reloaded with a count of `SEG_BEATS` and a destination of (partner destination + `SEG_BEATS*LANES`) mod `BUF_SEGS*SEG_BEATS*LANES`. Successive writes therefore have contiguous addresses across segment boundaries.
- R7: After `BUF_SEGS*SEG_BEATS` accepted strobes, the next write address is 0, and `wr_addr` always stays below the buffer size.
- R8: A strobe that arrives while no channel is enabled produces no write and sets `overrun`. `overrun` stays at 1 until the next `start`.
- R9: `start` takes priority over a strobe in the same cycle. That strobe produces no write and does not set `overrun`. `start` clears `overrun`, and the run restarts on channel 0 at address 0 whatever the previous state.
- R10: `wr_data` packs lane k of the trigger in bits [k*DATA_W +: DATA_W], unchanged from `sample_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Arm both channels and begin at address 0 |
| sample_vld | input | 1 | Sample-ready strobe, one beat per high cycle |
| sample_data | input | LANES*DATA_W | Converter results of one trigger, lane 0 in the LSBs |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | $clog2(BUF_SEGS*SEG_BEATS*LANES) | Result index of lane 0 of this write |
| wr_data | output | LANES*DATA_W | Packed results to store |
| active_ch | output | 1 | Index of the enabled channel |
| overrun | output | 1 | Sticky flag: a strobe arrived with no channel enabled |

## Verification
The write, its address and its data appear one cycle after the edge that samples the strobe. `active_ch` changes on that same edge, so it already names the new channel when the last write of a segment is seen. `overrun` is set, and cleared by `start`, with the same one-cycle delay. The reference model advances on each rising edge using the inputs applied half a cycle earlier. The outputs are compared on the following falling edge, which is exactly one register stage later. The stimulus covers back-to-back strobes across handovers, sparse strobes, a full wrap of the buffer, strobes before `start`, and a `start` issued mid-segment together with a strobe.

// File: rtl/pp_xfer_pkg.sv
package pp_xfer_pkg;
  localparam int unsigned MAX_SEG_BEATS = 65536;

  function automatic int unsigned seg_base(input int unsigned idx,
                                           input int unsigned seg_elems,
                                           input int unsigned buf_elems);
    return (idx * seg_elems) % buf_elems;
  endfunction
endpackage

// File: rtl/pp_xfer_chan.sv
module pp_xfer_chan #(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned SEG_BEATS = 2500,
  parameter int unsigned LANES     = 4,
  parameter int unsigned BUF_ELEMS = 100000,
  parameter int unsigned INIT_DEST = 0,
  parameter bit          INIT_EN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] partner_dest_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] dest_o,
  output logic              last_o
);
  localparam int unsigned SEG_ELEMS = SEG_BEATS * LANES;
  localparam logic [ADDR_W:0]   SEG_X  = (ADDR_W+1)'(SEG_ELEMS);
  localparam logic [ADDR_W:0]   BUF_X  = (ADDR_W+1)'(BUF_ELEMS);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(LANES);
  localparam logic [CNT_W-1:0]  FULL_C = CNT_W'(SEG_BEATS);
  localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);

  logic              en_q, en_d;
  logic [ADDR_W-1:0] dest_q, dest_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W:0]   reload_sum;
  logic [ADDR_W-1:0] reload_dest;
  logic              upd;

  assign last_o = (cnt_q == ONE_C);
  assign en_o   = en_q;
  assign dest_o = dest_q;

  always_comb begin
    reload_sum = {1'b0, partner_dest_i} + SEG_X;
    if (reload_sum >= BUF_X) reload_dest = ADDR_W'(reload_sum - BUF_X);
    else                     reload_dest = reload_sum[ADDR_W-1:0];
  end

  assign upd = start_i | step_i | take_i;

  always_comb begin
    en_d   = en_q;
    dest_d = dest_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      en_d   = INIT_EN;
      dest_d = ADDR_W'(INIT_DEST);
      cnt_d  = FULL_C;
    end else begin
      if (step_i) begin
        if (last_o) begin
          en_d   = 1'b0;
          dest_d = reload_dest;
          cnt_d  = FULL_C;
        end else begin
          dest_d = dest_q + STEP_A;
          cnt_d  = cnt_q - ONE_C;
        end
      end
      if (take_i) en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dest_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      en_q   <= en_d;
      dest_q <= dest_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cnt_q != '0 && cnt_q <= FULL_C)); // R2
  AST_STEP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> en_q); // R4
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && last_o && !start_i) |=> (cnt_q == FULL_C && !en_q)); // R6
  AST_DEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> ({1'b0, dest_q} < BUF_X)); // R7
endmodule

// File: rtl/pp_xfer_wport.sv
module pp_xfer_wport #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      en_q <= fire_i;
      if (fire_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign wr_en_o   = en_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(wr_data_o)); // R10
endmodule

// File: rtl/pp_xfer_pingpong.sv
module pp_xfer_pingpong #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned LANES     = 4,
  parameter int unsigned SEG_BEATS = 2500,
  parameter int unsigned BUF_SEGS  = 10,
  localparam int unsigned SEG_ELEMS = SEG_BEATS * LANES,
  localparam int unsigned BUF_ELEMS = SEG_ELEMS * BUF_SEGS,
  localparam int unsigned ADDR_W    = (BUF_ELEMS > 1) ? $clog2(BUF_ELEMS) : 1,
  localparam int unsigned WORD_W    = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample_vld,
  input  logic [WORD_W-1:0] sample_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              active_ch,
  output logic              overrun
);
  import pp_xfer_pkg::*;

  localparam int unsigned CNT_W = $clog2(SEG_BEATS + 1);
  localparam int unsigned NCH   = 2;

  if (SEG_BEATS > MAX_SEG_BEATS || SEG_BEATS < 1 || BUF_SEGS < 2) begin : g_bad_cfg
    $error("pp_xfer_pingpong: segment length or segment count out of range");
  end

  logic [NCH-1:0]    ch_en, ch_last, ch_step, ch_take;
  logic [ADDR_W-1:0] ch_dest [NCH];
  logic              any_en, fire, ovr_q, ovr_d;
  logic [ADDR_W-1:0] cur_dest;

  assign any_en = |ch_en;
  assign fire   = sample_vld & ~start & any_en;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int unsigned PARTNER = NCH - 1 - i;
    assign ch_step[i] = sample_vld & ~start & ch_en[i];
    assign ch_take[i] = ch_step[PARTNER] & ch_last[PARTNER];

    pp_xfer_chan #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .SEG_BEATS (SEG_BEATS),
      .LANES     (LANES),
      .BUF_ELEMS (BUF_ELEMS),
      .INIT_DEST (seg_base(i, SEG_ELEMS, BUF_ELEMS)),
      .INIT_EN   (i == 0)
    ) u_chan (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start),
      .step_i         (ch_step[i]),
      .take_i         (ch_take[i]),
      .partner_dest_i (ch_dest[PARTNER]),
      .en_o           (ch_en[i]),
      .dest_o         (ch_dest[i]),
      .last_o         (ch_last[i])
    );
  end

  assign cur_dest  = ch_en[1] ? ch_dest[1] : ch_dest[0];
  assign active_ch = ch_en[1];

  pp_xfer_wport #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_wport (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .addr_i    (cur_dest),
    .data_i    (sample_data),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (start)                     ovr_d = 1'b0;
    else if (sample_vld && !any_en) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun = ovr_q;

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en)); // R4
  AST_HANDOVER_0: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_step[0] && ch_last[0] && !start) |=> (ch_en[1] && !ch_en[0])); // R5
  AST_HANDOVER_1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_step[1] && ch_last[1] && !start) |=> (ch_en[0] && !ch_en[1])); // R5
  AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !start && any_en) |=> wr_en); // R3
  AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> !wr_en); // R3
  AST_IDLE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !start && !any_en) |=> (!wr_en && overrun)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !start) |=> overrun); // R8
  AST_START_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!wr_en && !overrun && !active_ch && ch_en[0])); // R9
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < BUF_ELEMS)); // R7
endmodule

// File: tb/tb_pp_xfer_pingpong.sv
module tb_pp_xfer_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 12;
  localparam int LN   = 4;
  localparam int SEG  = 5;
  localparam int NSEG = 3;
  localparam int BUFE = SEG * LN * NSEG;
  localparam int AW   = $clog2(BUFE);
  localparam int WW   = DW * LN;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sample_vld = 1'b0;
  logic [WW-1:0] sample_data = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] wr_data;
  logic          active_ch;
  logic          overrun;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // reference model state
  bit            m_started = 0;
  int            m_addr = 0;
  int            m_beat = 0;
  int            e_ch = 0;
  bit            e_ovr = 0;
  bit            e_wr = 0;
  int            e_addr = 0;
  logic [WW-1:0] e_data = '0;
  bit            m_valid = 0;

  pp_xfer_pingpong #(.DATA_W(DW), .LANES(LN), .SEG_BEATS(SEG), .BUF_SEGS(NSEG)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_vld(sample_vld),
    .sample_data(sample_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .active_ch(active_ch), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    m_valid = 1;
    if (!rst_n) begin
      m_started = 0; m_addr = 0; m_beat = 0; e_ch = 0; e_ovr = 0; e_wr = 0;
    end else if (start) begin
      m_started = 1; m_addr = 0; m_beat = 0; e_ch = 0; e_ovr = 0; e_wr = 0;
    end else if (sample_vld) begin
      if (!m_started) begin
        e_ovr = 1; e_wr = 0;
      end else begin
        e_wr = 1; e_addr = m_addr; e_data = sample_data;
        m_addr = (m_addr + LN) % BUFE;
        m_beat = m_beat + 1;
        if (m_beat == SEG) begin m_beat = 0; e_ch = 1 - e_ch; end
      end
    end else begin
      e_wr = 0;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every falling edge, one register stage after the sampling edge
  always @(negedge clk) begin
    if (m_valid) begin
      chk(wr_en === e_wr, "wr_en (R3)", longint'(wr_en), longint'(e_wr));
      chk(overrun === e_ovr, "overrun (R8)", longint'(overrun), longint'(e_ovr));
      chk(active_ch === e_ch[0], "active_ch (R4/R5)", longint'(active_ch), longint'(e_ch));
      if (e_wr) begin
        chk(int'(wr_addr) == e_addr, "wr_addr (R6/R7)", longint'(wr_addr), longint'(e_addr));
        chk(wr_data === e_data, "wr_data (R10)", longint'(wr_data), longint'(e_data));
      end
    end
  end

  task automatic beat(input bit vld, input bit st);
    @(negedge clk);
    start = st;
    sample_vld = vld;
    sample_data = {$urandom, $urandom};
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    beat(0, 0); beat(0, 0);
    // R8: strobe with no channel enabled
    tag = "R8";
    beat(1, 0); beat(0, 0); beat(1, 0); beat(0, 0);
    // R9: start together with a strobe; R2 first write at 0 on channel 0
    tag = "R9";
    beat(1, 1); beat(0, 0);
    // R3 R5 R6 R7: back-to-back through two full buffer wraps
    tag = "R5";
    for (int i = 0; i < 2 * SEG * NSEG + 3; i++) beat(1, 0);
    beat(0, 0);
    // R3 sparse strobes across handovers
    tag = "R3";
    for (int i = 0; i < 40; i++) beat((i % 3) != 1, 0);
    // R9 mid-segment restart
    tag = "R9";
    beat(1, 0); beat(1, 1);
    tag = "R7";
    for (int i = 0; i < SEG * NSEG + 2; i++) beat(1, 0);
    beat(0, 0); beat(0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule